// File: doc/BRIEF.md
# Prescaled Up-Counting Interrupt Timer

This block raises an interrupt after a programmable number of CPU cycles. Software first loads an 8-bit reload value, one 4-bit half at a time. It then writes a control byte that arms the timer. While the timer runs, a fixed prescaler divides the CPU cycle enable by 114. Each prescaler period advances an 8-bit counter upward by one.

When the counter is at 0xFF and takes one more step, it reloads from the reload value and the interrupt line goes high. On that event the timer either re-arms itself or stops, depending on a repeat bit in the control byte. The interrupt line is a sticky level. Only reset or a new control write lowers it.

The address decode keeps only address bits 15:12 and 3:2 (mask 0xF00C). Writes whose masked address matches none of the three timer registers are ignored.

Top module: `cyc_irq_timer`

## Requirements
- R1: Reset clears the interrupt line, the control field, the counter, the reload value and the prescaler. An arm right after reset therefore fires 114*256 enabled cycles later.
- R2: A write with (addr & 0xF00C) == 0xF000 sets reload bits 3:0, and one with 0xF004 sets reload bits 7:4. Both take their value from wdata[3:0]. Writes to any other masked address leave the timer unchanged.
- R3: A write with (addr & 0xF00C) == 0xF008 stores wdata[1:0] as the control field (bit 1 run, bit 0 repeat). When wdata[1] is 1, the same write loads the counter from the reload value and clears the prescaler, which restarts the timing.
- R4: The prescaler advances only on cycles where cpu_ce is 1 and the run bit is set. Every 114th such cycle, the counter steps by one.
- R5: A counter step taken at 0xFF reloads the counter and raises irq. With reload value L, irq rises 114*(256-L) enabled cycles after the arming write.
- R6: On firing, the control field becomes 3 if the repeat bit was set and 0 otherwise. In both modes irq stays high until it is acknowledged.
- R7: Any control write, whatever its data, lowers irq on the next clock. A control write in the same cycle as a firing step wins, so irq stays low.
- R8: A control write with wdata[1] = 0 stops the counting, and no interrupt follows.
- R9: Writing the reload value while the timer runs does not change the running counter. The new value is used only at the next load or wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ce | input | 1 | One-cycle CPU cycle enable |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 16 | Write address |
| wdata | input | 8 | Write data |
| irq | output | 1 | Active-high sticky interrupt level |

## Verification
The only visible result is the cycle on which irq rises. A prescaler off by one period, a counter that misses a step, or a reload taken from the wrong place therefore shows up only as a rise that comes too early, too late or not at all. That error can appear up to about 29,000 cycles after the arming write. The bench predicts every rise to the exact clock edge, so an error of a single cycle in timing is caught. A wrong repeat or ignore behaviour becomes visible only through a missing or extra rise after an acknowledge, or through a write that shifts the next rise.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] DEC_MASK   = 16'hF00C;
    localparam logic [ADDR_W-1:0] DEC_RLD_LO = 16'hF000;
    localparam logic [ADDR_W-1:0] DEC_RLD_HI = 16'hF004;
    localparam logic [ADDR_W-1:0] DEC_CTRL   = 16'hF008;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_RLD_LO,
        SEL_RLD_HI,
        SEL_CTRL
    } sel_e;

    // control field: run is data bit 1, rpt is data bit 0
    typedef struct packed {
        logic run;
        logic rpt;
    } mode_t;

    function automatic sel_e decode_sel(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] m;
        m = a & DEC_MASK;
        if (m == DEC_RLD_LO)      return SEL_RLD_LO;
        else if (m == DEC_RLD_HI) return SEL_RLD_HI;
        else if (m == DEC_CTRL)   return SEL_CTRL;
        else                      return SEL_NONE;
    endfunction

    function automatic mode_t mode_after_fire(input mode_t m);
        mode_t r;
        r.run = m.rpt;
        r.rpt = m.rpt;
        return r;
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                fire,
    output logic [CNT_W-1:0]    reload,
    output mode_t               mode,
    output logic                ctrl_wr,
    output logic                arm
);
    localparam int HALF = CNT_W / 2;

    sel_e sel;
    logic unused_wdata_hi;

    assign sel     = wr_en ? decode_sel(addr) : SEL_NONE;
    assign ctrl_wr = (sel == SEL_CTRL);
    assign arm     = ctrl_wr & wdata[1];
    assign unused_wdata_hi = ^wdata[DATA_W-1:HALF];

    always_ff @(posedge clk) begin
        if (rst) begin
            reload <= '0;
        end else if (sel == SEL_RLD_LO) begin
            reload[HALF-1:0] <= wdata[HALF-1:0];
        end else if (sel == SEL_RLD_HI) begin
            reload[CNT_W-1:HALF] <= wdata[HALF-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
        end else if (ctrl_wr) begin
            mode <= mode_t'(wdata[1:0]);
        end else if (fire) begin
            mode <= mode_after_fire(mode);
        end
    end

    // R3
    ctrl_store_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> mode == mode_t'($past(wdata[1:0])));

    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !ctrl_wr && !mode.rpt) |=> (mode == '0));

    // R6
    repeat_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !ctrl_wr && mode.rpt) |=> (mode.run && mode.rpt));

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV = 114
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic ce,
    input  logic clear,
    output logic tick
);
    localparam int PW = $clog2(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pcnt;

    assign tick = run && ce && !clear && (pcnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pcnt <= '0;
        end else if (run && ce) begin
            pcnt <= (pcnt == LAST) ? '0 : pcnt + 1'b1;
        end
    end

    // R4
    pre_range_chk: assert property (@(posedge clk) disable iff (rst)
        pcnt <= LAST);

    // R4
    pre_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (pcnt == '0));

    // R8
    pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !clear) |=> $stable(pcnt));

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    input  logic             tick,
    output logic             fire
);
    logic [CNT_W-1:0] cnt;

    assign fire = tick && !load && (&cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= reload;
        end else if (tick) begin
            cnt <= (&cnt) ? reload : cnt + 1'b1;
        end
    end

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(cnt));

    // R5
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> (cnt == $past(reload)));

    // R3
    cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(reload)));

endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
    import tmr_pkg::*;
#(
    parameter int PRESCALE = 114,
    parameter int CNT_W    = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_ce,
    input  logic        wr_en,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output logic        irq
);
    logic [CNT_W-1:0] reload;
    mode_t            mode;
    logic             ctrl_wr;
    logic             arm;
    logic             tick;
    logic             fire;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .fire(fire), .reload(reload), .mode(mode), .ctrl_wr(ctrl_wr), .arm(arm)
    );

    tmr_prescale #(.DIV(PRESCALE)) u_pre (
        .clk(clk), .rst(rst), .run(mode.run), .ce(cpu_ce), .clear(arm),
        .tick(tick)
    );

    tmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(arm), .reload(reload), .tick(tick),
        .fire(fire)
    );

    always_ff @(posedge clk) begin
        if (rst || ctrl_wr) begin
            irq <= 1'b0;
        end else if (fire) begin
            irq <= 1'b1;
        end
    end

    // R7
    irq_ack_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> !irq);

    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(fire));

    // R6
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !ctrl_wr) |=> irq);

    // R4
    tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> (cpu_ce && mode.run));

endmodule

// File: tb/cyc_irq_timer_bench.sv
module cyc_irq_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 114;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_ce = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        irq;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];
    bit ce_half = 1'b0;
    logic irq_prev = 1'b0;

    cyc_irq_timer u_cyc_irq_timer (
        .clk(clk), .rst(rst), .cpu_ce(cpu_ce), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // enable pattern for the edge that follows this falling edge
    always @(negedge clk) cpu_ce = !ce_half || (((cyc + 1) % 2) == 0);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, exp, cyc);
        end
    endtask

    // scoreboard monitor: every irq rise must match the next predicted edge
    always @(negedge clk) begin
        if (!rst && irq && !irq_prev) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected irq rise", cyc, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(cyc == e, "R5 irq rise edge", cyc, e);
            end
        end
        irq_prev = irq;
    end

    // called on a falling edge; returns the edge number that samples the write
    task automatic wr(input logic [15:0] a, input logic [7:0] d, output int edge_n);
        addr = a; wdata = d; wr_en = 1'b1;
        edge_n = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_to(input int e);
        while (cyc < e) @(negedge clk);
    endtask

    task automatic set_reload(input logic [7:0] v);
        int w;
        wr(16'hF000, {4'h0, v[3:0]}, w);
        wr(16'hF004, {4'h0, v[7:4]}, w);
    endtask

    initial begin
        int w, w2;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);

        // R1 reload value cleared: arm without loading reload -> 256 steps
        wr(16'hF008, 8'h02, w);
        exp_q.push_back(w + DIV * 256);
        wait_to(w + DIV * 256 - 1);
        chk(irq == 1'b0, "R1 irq one edge before full period", irq, 0);
        wait_to(w + DIV * 256 + 2);
        chk(irq == 1'b1, "R1 irq after full period", irq, 1);

        // R7 acknowledge with data 0
        wr(16'hF008, 8'h00, w);
        chk(irq == 1'b0, "R7 ack lowers irq", irq, 0);

        // R2 aliased reload addresses, foreign addresses ignored
        wr(16'hF0F0, 8'hAC, w);
        wr(16'hF3F4, 8'h5F, w);
        wr(16'hE000, 8'h00, w);
        wr(16'hF00C, 8'h00, w);
        wr(16'hF00D, 8'h03, w);
        chk(irq == 1'b0, "R2 foreign write no irq", irq, 0);
        wr(16'hF008, 8'h02, w);
        exp_q.push_back(w + DIV * 4);
        wait_to(w + DIV * 4 + 2);
        chk(irq == 1'b1, "R2 reload FC gives 4 steps", irq, 1);

        // R6 one-shot keeps irq high with no further rises
        wait_to(cyc + 3 * DIV * 4);
        chk(irq == 1'b1, "R6 one-shot irq sticky", irq, 1);
        wr(16'hF008, 8'h00, w);
        chk(irq == 1'b0, "R7 ack after one-shot", irq, 0);
        wait_to(cyc + 600);
        chk(irq == 1'b0, "R6 one-shot no refire", irq, 0);

        // R6 repeat mode, then R8 stop via control write with run clear
        set_reload(8'hFE);
        wr(16'hF008, 8'h03, w);
        exp_q.push_back(w + DIV * 2);
        wait_to(w + DIV * 2 + 2);
        chk(irq == 1'b1, "R6 repeat first fire", irq, 1);
        wait_to(cyc + 700);
        chk(irq == 1'b1, "R6 repeat irq held over wraps", irq, 1);
        wr(16'hF008, 8'h01, w);
        chk(irq == 1'b0, "R7 ack with run clear", irq, 0);
        wait_to(cyc + 500);
        chk(irq == 1'b0, "R8 stopped timer stays quiet", irq, 0);

        // R9 reload rewritten mid-run does not move the running count
        set_reload(8'hFC);
        wr(16'hF008, 8'h02, w);
        exp_q.push_back(w + DIV * 4);
        wait_to(w + 100);
        set_reload(8'h00);
        wait_to(w + DIV * 4 - 1);
        chk(irq == 1'b0, "R9 no early fire", irq, 0);
        wait_to(w + DIV * 4 + 2);
        chk(irq == 1'b1, "R9 fire on original schedule", irq, 1);
        wr(16'hF008, 8'h00, w);

        // R4 cpu_ce on every other cycle doubles the period
        set_reload(8'hFE);
        ce_half = 1'b1;
        @(negedge clk);
        while (((cyc + 1) % 2) != 0) @(negedge clk);
        wr(16'hF008, 8'h02, w);
        exp_q.push_back(w + 2 * DIV * 2);
        wait_to(w + 2 * DIV * 2 - 1);
        chk(irq == 1'b0, "R4 gapped enable no early fire", irq, 0);
        wait_to(w + 2 * DIV * 2 + 2);
        chk(irq == 1'b1, "R4 gapped enable fire", irq, 1);
        ce_half = 1'b0;
        @(negedge clk);
        wr(16'hF008, 8'h00, w);

        // R3 re-arming restarts the prescaler and counter
        wr(16'hF008, 8'h02, w);
        wait_to(w + 200);
        wr(16'hF008, 8'h02, w2);
        exp_q.push_back(w2 + DIV * 2);
        wait_to(w + DIV * 2 + 2);
        chk(irq == 1'b0, "R3 old schedule cancelled", irq, 0);
        wait_to(w2 + DIV * 2 + 2);
        chk(irq == 1'b1, "R3 restarted schedule fires", irq, 1);
        wr(16'hF008, 8'h00, w);

        // R7 control write on the firing edge wins
        set_reload(8'hFF);
        wr(16'hF008, 8'h02, w);
        wait_to(w + DIV - 1);
        wr(16'hF008, 8'h00, w2);
        chk(w2 == w + DIV, "R7 write lands on firing edge", w2, w + DIV);
        wait_to(w + DIV + 10);
        chk(irq == 1'b0, "R7 same-edge write suppresses irq", irq, 0);

        chk(exp_q.size() == 0, "R5 all predicted rises seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule